// File: doc/BRIEF.md
# Serial-Command 64x16 EEPROM Model

This block models a small word-organised serial EEPROM behind a three-line command interface plus one data return line. A host raises a select line and clocks bits in on a slow serial clock. The block runs on a fast system clock, synchronises the three host lines and finds each rising edge of the serial clock by oversampling. Each transaction begins with a start bit. An 8-bit command then follows: two operation bits and a 6-bit address. Program commands carry a 16-bit data word after the command. Reads stream words out of the array with an address that increments and wraps.

Storage is a synchronous single-port array that FPGA block RAM can hold. After reset the array is cleared to zero by a sweep. A parallel load port can then preload it while the select line is low. Program operations are gated by a write-enable latch. Their completion is signalled on the data return line by a select-line handshake: the line reads low (busy) after select falls and high (ready) after select rises again.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, ser_dout is 0, the write-enable latch is clear and every word of the array reads as 0x0000 once DEPTH system cycles have passed.
- R2: Command bit order is start bit (1), op[1:0], then address[5:0], all MSB first. op 10 reads. The addressed word appears on ser_dout MSB first, one bit per serial-clock rising edge, starting at the first rising edge after the last address bit.
- R3: While select stays high, a read continues after each 16 bits with the next address, and address 63 is followed by address 0.
- R4: op 01 shifts in 16 data bits MSB first and stores them at the address when writes are enabled.
- R5: op 11 sets the addressed word to 0xFFFF when writes are enabled.
- R6: op 00 with address bits [5:4]=01 shifts in 16 data bits and stores them in every word when writes are enabled.
- R7: op 00 with address bits [5:4]=10 sets every word to 0xFFFF when writes are enabled.
- R8: op 00 with address bits [5:4]=11 sets the write-enable latch, and [5:4]=00 clears it. While the latch is clear, write, erase, write-all and erase-all leave the array unchanged.
- R9: After any program command, even a gated one, ser_dout goes low once select falls and goes high once select rises again.
- R10: If select falls during command or data input, the operation is dropped, ser_dout goes low and no word is changed.
- R11: With select low, a load_en pulse writes load_data into word load_addr.
- R12: Serial-clock edges while select is low, and rising edges with data low while idle, start nothing and change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel | input | 1 | Asynchronous select from host, active high |
| ser_clk | input | 1 | Asynchronous serial clock from host |
| ser_din | input | 1 | Asynchronous serial data from host |
| ser_dout | output | 1 | Registered serial data / busy-ready to host |
| load_en | input | 1 | Parallel preload strobe |
| load_addr | input | ADDR_W | Preload word address |
| load_data | input | DATA_W | Preload word value |

## Verification
The bench builds the block with its defaults, ADDR_W=6 and DATA_W=16, so it exercises the full 64-word map. At this depth the wrap from word 63 to word 0 falls inside a three-word streamed read. The whole-array write and erase sweeps are 64 cycles long, which is short next to a select handshake, so the bench can check their busy and ready levels at fixed delays. Each serial-clock phase lasts six system cycles, well above the synchroniser and prefetch latency.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [3:0] {
    ST_CLEAR, ST_IDLE, ST_CMD, ST_DATA, ST_FETCH_A, ST_FETCH_B,
    ST_SHIFT_OUT, ST_STORE, ST_FILL, ST_WAIT_FALL, ST_WAIT_RISE
  } mwe_state_e;

  localparam logic [1:0] GRP_EXT   = 2'b00;
  localparam logic [1:0] GRP_WRITE = 2'b01;
  localparam logic [1:0] GRP_READ  = 2'b10;
  localparam logic [1:0] GRP_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK      = 2'b00;
  localparam logic [1:0] EXT_FILL_DATA = 2'b01;
  localparam logic [1:0] EXT_FILL_ONES = 2'b10;
  localparam logic [1:0] EXT_UNLOCK    = 2'b11;
endpackage

// File: rtl/mwe_sync.sv
module mwe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mwe_mem.sv
module mwe_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/mwe_ctrl.sv
module mwe_ctrl
  import mwe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dout,
  output mwe_state_e        state,
  output logic              wen
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2((DATA_W > CMD_W) ? DATA_W : CMD_W);

  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  cmd_next;
  logic [DATA_W-1:0] word_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] fill_cnt;
  logic              fill_all;
  logic [1:0]        grp;
  logic [1:0]        ext;

  assign cmd_next = {cmd_sr, din_s};
  assign grp      = cmd_next[CMD_W-1 -: 2];
  assign ext      = cmd_next[ADDR_W-1 -: 2];

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = word_sr;
    if (state == ST_STORE) begin
      mem_we = 1'b1;
    end else if (state == ST_FILL || state == ST_CLEAR) begin
      mem_we   = 1'b1;
      mem_addr = fill_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CLEAR;
      wen      <= 1'b0;
      dout     <= 1'b0;
      cmd_sr   <= '0;
      word_sr  <= '0;
      bit_cnt  <= '0;
      addr_q   <= '0;
      fill_cnt <= '0;
      fill_all <= 1'b0;
    end else begin
      unique case (state)
        ST_CLEAR, ST_FILL: begin
          fill_cnt <= fill_cnt + ADDR_W'(1);
          if (&fill_cnt) state <= (state == ST_CLEAR) ? ST_IDLE : ST_WAIT_FALL;
        end
        ST_STORE: state <= ST_WAIT_FALL;
        ST_WAIT_FALL: if (!cs_s) begin
          dout  <= 1'b0;
          state <= ST_WAIT_RISE;
        end
        ST_WAIT_RISE: if (cs_s) begin
          dout  <= 1'b1;
          state <= ST_IDLE;
        end
        default: begin
          if (!cs_s) begin
            if (state == ST_CMD || state == ST_DATA) dout <= 1'b0;
            state <= ST_IDLE;
          end else begin
            unique case (state)
              ST_IDLE: if (sk_rise && din_s) begin
                state   <= ST_CMD;
                bit_cnt <= '0;
                cmd_sr  <= '0;
              end
              ST_CMD: if (sk_rise) begin
                cmd_sr  <= cmd_next[CMD_W-2:0];
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                  bit_cnt  <= '0;
                  fill_cnt <= '0;
                  unique case (grp)
                    GRP_ERASE: begin
                      addr_q  <= cmd_next[ADDR_W-1:0];
                      word_sr <= '1;
                      state   <= wen ? ST_STORE : ST_WAIT_FALL;
                    end
                    GRP_READ: begin
                      addr_q <= cmd_next[ADDR_W-1:0];
                      state  <= ST_FETCH_A;
                    end
                    GRP_WRITE: begin
                      addr_q   <= cmd_next[ADDR_W-1:0];
                      word_sr  <= '0;
                      fill_all <= 1'b0;
                      state    <= ST_DATA;
                    end
                    default: begin
                      unique case (ext)
                        EXT_LOCK: begin
                          wen   <= 1'b0;
                          state <= ST_IDLE;
                        end
                        EXT_FILL_DATA: begin
                          word_sr  <= '0;
                          fill_all <= 1'b1;
                          state    <= ST_DATA;
                        end
                        EXT_FILL_ONES: begin
                          word_sr <= '1;
                          state   <= wen ? ST_FILL : ST_WAIT_FALL;
                        end
                        default: begin
                          wen   <= 1'b1;
                          state <= ST_IDLE;
                        end
                      endcase
                    end
                  endcase
                end
              end
              ST_DATA: if (sk_rise) begin
                word_sr <= {word_sr[DATA_W-2:0], din_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                  if (!wen)         state <= ST_WAIT_FALL;
                  else if (fill_all) state <= ST_FILL;
                  else              state <= ST_STORE;
                end
              end
              ST_FETCH_A: state <= ST_FETCH_B;
              ST_FETCH_B: begin
                word_sr <= rdata;
                bit_cnt <= '0;
                state   <= ST_SHIFT_OUT;
              end
              ST_SHIFT_OUT: if (sk_rise) begin
                dout    <= word_sr[DATA_W-1];
                word_sr <= {word_sr[DATA_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                  addr_q <= addr_q + ADDR_W'(1);
                  state  <= ST_FETCH_A;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mwe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data
);
  logic [2:0]        sync_q;
  logic              cs_s, sk_s, din_s, sk_prev, sk_rise;
  logic              ctrl_we, mem_we;
  logic [ADDR_W-1:0] ctrl_addr, mem_addr;
  logic [DATA_W-1:0] ctrl_wdata, mem_wdata, rdata;
  mwe_state_e        state;
  logic              wen;

  mwe_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ser_sel, ser_clk, ser_din}),
    .sync_out(sync_q)
  );
  assign {cs_s, sk_s, din_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sk_prev <= 1'b0;
    else     sk_prev <= sk_s;
  end
  assign sk_rise = sk_s & ~sk_prev;

  mwe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sk_rise(sk_rise), .din_s(din_s),
    .rdata(rdata), .mem_we(ctrl_we), .mem_addr(ctrl_addr),
    .mem_wdata(ctrl_wdata), .dout(ser_dout), .state(state), .wen(wen)
  );

  always_comb begin
    mem_we    = ctrl_we;
    mem_addr  = ctrl_addr;
    mem_wdata = ctrl_wdata;
    if (!ctrl_we && load_en && !cs_s) begin
      mem_we    = 1'b1;
      mem_addr  = load_addr;
      mem_wdata = load_data;
    end
  end

  mwe_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(rdata)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mwe_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       sk_rise,
  input logic       ser_dout,
  input logic       ctrl_we,
  input logic       wen,
  input mwe_state_e state
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  a_r1_reset_dout: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !ser_dout);

  a_r8_store_gated: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && state != ST_CLEAR) |-> wen);

  a_r10_abandon: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CMD || state == ST_DATA) && !cs_s) |=> (!ser_dout && state == ST_IDLE));

  a_r9_busy_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_RISE) |-> !ser_dout);

  a_r12_dout_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_dout) |-> ($past(sk_rise) || !$past(cs_s) || $past(state) == ST_WAIT_RISE));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .sk_rise(sk_rise), .ser_dout(ser_dout),
  .ctrl_we(ctrl_we), .wen(wen), .state(state)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int HALF = 6;

  logic clk = 0, rst = 1;
  logic ser_sel = 0, ser_clk = 0, ser_din = 0;
  logic ser_dout;
  logic load_en = 0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [64];
  logic wen_m = 0;

  localparam logic [21:0] VEC [6] = '{
    {6'd0, 16'hA5C3}, {6'd63, 16'h0F0F}, {6'd62, 16'h8001},
    {6'd17, 16'hFFFE}, {6'd33, 16'h7FFF}, {6'd7, 16'h5A5A}
  };

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ser_sel(ser_sel), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    ser_din = b;
    wait_n(HALF);
    ser_clk = 1;
    wait_n(HALF);
    ser_clk = 0;
  endtask

  task automatic send_cmd(input logic [7:0] cmd);
    ser_sel = 1;
    wait_n(4);
    sk_bit(1'b1);
    for (int i = 7; i >= 0; i--) sk_bit(cmd[i]);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) sk_bit(d[i]);
  endtask

  task automatic end_quiet();
    ser_din = 0;
    ser_sel = 0;
    wait_n(8);
  endtask

  task automatic finish_prog();
    ser_din = 0;
    ser_sel = 0;
    wait_n(90);
    check("R9 busy", {15'd0, ser_dout}, 16'd0);
    ser_sel = 1;
    wait_n(8);
    check("R9 ready", {15'd0, ser_dout}, 16'd1);
    ser_sel = 0;
    wait_n(8);
  endtask

  task automatic set_enable(input logic en);
    send_cmd(en ? 8'b0011_0000 : 8'b0000_0000);
    end_quiet();
    wen_m = en;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    send_cmd({2'b01, a});
    send_data(d);
    finish_prog();
    if (wen_m) model[a] = d;
  endtask

  task automatic erase_word(input logic [AW-1:0] a);
    send_cmd({2'b11, a});
    finish_prog();
    if (wen_m) model[a] = 16'hFFFF;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input int n);
    send_cmd({2'b10, a});
    for (int w = 0; w < n; w++) begin
      logic [DW-1:0] got = '0;
      for (int b = 0; b < DW; b++) begin
        ser_din = 0;
        wait_n(HALF);
        ser_clk = 1;
        wait_n(HALF);
        got = {got[DW-2:0], ser_dout};
        ser_clk = 0;
      end
      check(req, got, model[AW'(a + AW'(w))]);
    end
    end_quiet();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    wait_n(4);
    rst = 0;
    wait_n(80);
    // R1: reset state
    check("R1 dout after reset", {15'd0, ser_dout}, 16'd0);
    read_check("R1 cleared word", 6'd5, 1);
    // R8 / R1: latch clear after reset, write has no effect
    write_word(6'd3, 16'h1234);
    read_check("R8 gated write after reset", 6'd3, 1);

    // R11: preload while select low
    @(negedge clk);
    load_en = 1; load_addr = 6'd10; load_data = 16'hBEEF;
    @(negedge clk);
    load_addr = 6'd11; load_data = 16'h0123;
    @(negedge clk);
    load_en = 0;
    model[10] = 16'hBEEF; model[11] = 16'h0123;
    read_check("R11 preload", 6'd10, 2);

    set_enable(1'b1);
    // R4: table walk, write then read back
    for (int i = 0; i < 6; i++) begin
      write_word(VEC[i][21:16], VEC[i][15:0]);
      read_check("R4 write/readback", VEC[i][21:16], 1);
    end

    // R2 and R3: streamed read across the wrap
    read_check("R3 sequential wrap", 6'd62, 3);
    read_check("R2 single read", 6'd17, 1);

    // R5: erase single word
    erase_word(6'd33);
    read_check("R5 erase", 6'd33, 1);

    // R8: disable blocks write and erase
    set_enable(1'b0);
    write_word(6'd7, 16'h1111);
    erase_word(6'd0);
    read_check("R8 locked write", 6'd7, 1);
    read_check("R8 locked erase", 6'd0, 1);
    set_enable(1'b1);

    // R10: drop select mid-data; dout was high (ready) before
    write_word(6'd20, 16'hC0DE);
    check("R10 dout high before", {15'd0, ser_dout}, 16'd1);
    send_cmd({2'b01, 6'd20});
    sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1);
    end_quiet();
    check("R10 dout cleared", {15'd0, ser_dout}, 16'd0);
    read_check("R10 word kept", 6'd20, 1);

    // R12: clocks with select low carry an erase-all pattern; ignored
    ser_sel = 0;
    sk_bit(1'b1);
    for (int i = 7; i >= 0; i--) sk_bit(i == 5);
    wait_n(80);
    // R12: idle edges with data low, then a read
    ser_sel = 1;
    wait_n(4);
    sk_bit(1'b0); sk_bit(1'b0);
    ser_sel = 0;
    wait_n(8);
    read_check("R12 ignored edges", 6'd62, 2);

    // R6: write-all
    send_cmd(8'b0001_0000);
    send_data(16'h3C96);
    finish_prog();
    for (int i = 0; i < 64; i++) model[i] = 16'h3C96;
    read_check("R6 write-all", 6'd63, 2);
    read_check("R6 write-all mid", 6'd31, 1);

    // R7: erase-all
    send_cmd(8'b0010_0000);
    finish_prog();
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    read_check("R7 erase-all", 6'd0, 2);
    read_check("R7 erase-all top", 6'd63, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule